// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Unit

This unit holds the shared event flags of a five-channel DMA engine. Each channel reports three single-cycle event pulses: end of transfer, midpoint of transfer and transfer fault. The unit latches each pulse into a sticky flag. It also derives a per-channel summary bit that is set while any of the channel's three flags is set.

Software reads all flags through one 20-bit status word. It clears them by writing a 20-bit clear word whose layout matches the status word. A one clears the matching flag, and a zero leaves it alone. A one in a channel's summary position clears all three of that channel's flags at once.

Each channel drives one interrupt line. The line goes high when any of the channel's flags is set and that flag's enable is also set. Flags latch whatever the enables are, so software can also poll them.

Top module: `dma_irq_status`

## Requirements
- R1: During a synchronous active-low reset, and on the cycle that follows it, every status bit and every interrupt line is 0.
- R2: An event pulse on channel n sets its flag from the next cycle on. The end-of-transfer flag is status bit 4n+1, the midpoint flag is bit 4n+2 and the fault flag is bit 4n+3. A flag stays set until it is cleared.
- R3: Status bit 4n, the channel summary, is 1 exactly when at least one of bits 4n+1..4n+3 is 1.
- R4: When the clear write strobe is high, each clear-word bit at 4n+1..4n+3 that is one clears the matching flag on the next cycle. Clear-word bits that are zero leave their flags unchanged.
- R5: A write with clear-word bit 4n set clears all three flags of channel n on the next cycle.
- R6: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Flags latch even when their interrupt enables are off. With enables off, the interrupt line stays low.
- R8: Interrupt line n is registered. It equals the OR over the three events of (flag AND enable), as sampled at the previous clock edge.
- R9: When the clear write strobe is low, the clear word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| evtDone | input | 5 | End-of-transfer event pulse, one per channel |
| evtHalf | input | 5 | Midpoint event pulse, one per channel |
| evtErr | input | 5 | Transfer fault event pulse, one per channel |
| enDone | input | 5 | End-of-transfer interrupt enable per channel |
| enHalf | input | 5 | Midpoint interrupt enable per channel |
| enErr | input | 5 | Fault interrupt enable per channel |
| clrWrEn | input | 1 | Clear word write strobe |
| clrWrData | input | 20 | Clear word, laid out like the status word |
| statusOut | output | 20 | Status word, 4 bits per channel: summary, end, midpoint, fault (low to high) |
| irqOut | output | 5 | Interrupt line per channel |

## Verification
An event pulse and a software clear of the same flag can arrive in the same cycle. This can happen through the flag's own clear bit or through the channel's summary clear bit. The bench provokes both cases directly. It also lets a random phase create many more such collisions, with sparse events and frequent random clear writes. Each cycle, a behavioural reference model applies the rule that the set wins, and the bench compares every status bit and interrupt line with that model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NCH      = 5;
  localparam int FLD_PER  = 4;
  localparam int STAT_W   = NCH * FLD_PER;
  localparam int F_GLB    = 0;
  localparam int F_DONE   = 1;
  localparam int F_HALF   = 2;
  localparam int F_ERR    = 3;

  typedef struct packed {
    logic [NCH-1:0] clrDone;
    logic [NCH-1:0] clrHalf;
    logic [NCH-1:0] clrErr;
  } clrStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrWrData,
  output clrStrobe_t        strb
);
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic wipeAll;
    assign wipeAll = clrWrData[c*FLD_PER + F_GLB];
    assign strb.clrDone[c] = clrWrEn & (clrWrData[c*FLD_PER + F_DONE] | wipeAll);
    assign strb.clrHalf[c] = clrWrEn & (clrWrData[c*FLD_PER + F_HALF] | wipeAll);
    assign strb.clrErr[c]  = clrWrEn & (clrWrData[c*FLD_PER + F_ERR]  | wipeAll);
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    evtDone,
  input  logic [NCH-1:0]    evtHalf,
  input  logic [NCH-1:0]    evtErr,
  input  logic [NCH-1:0]    enDone,
  input  logic [NCH-1:0]    enHalf,
  input  logic [NCH-1:0]    enErr,
  input  clrStrobe_t        strb,
  output logic [STAT_W-1:0] statusOut,
  output logic [NCH-1:0]    irqOut
);
  logic [NCH-1:0] doneQ, halfQ, errQ, irqQ;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        doneQ[c] <= 1'b0;
        halfQ[c] <= 1'b0;
        errQ[c]  <= 1'b0;
        irqQ[c]  <= 1'b0;
      end else begin
        // a pulse in the clear cycle keeps the flag set
        doneQ[c] <= evtDone[c] | (doneQ[c] & ~strb.clrDone[c]);
        halfQ[c] <= evtHalf[c] | (halfQ[c] & ~strb.clrHalf[c]);
        errQ[c]  <= evtErr[c]  | (errQ[c]  & ~strb.clrErr[c]);
        irqQ[c]  <= (doneQ[c] & enDone[c]) | (halfQ[c] & enHalf[c]) | (errQ[c] & enErr[c]);
      end
    end
    assign statusOut[c*FLD_PER + F_GLB]  = doneQ[c] | halfQ[c] | errQ[c];
    assign statusOut[c*FLD_PER + F_DONE] = doneQ[c];
    assign statusOut[c*FLD_PER + F_HALF] = halfQ[c];
    assign statusOut[c*FLD_PER + F_ERR]  = errQ[c];
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    evtDone,
  input  logic [NCH-1:0]    evtHalf,
  input  logic [NCH-1:0]    evtErr,
  input  logic [NCH-1:0]    enDone,
  input  logic [NCH-1:0]    enHalf,
  input  logic [NCH-1:0]    enErr,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrWrData,
  output logic [STAT_W-1:0] statusOut,
  output logic [NCH-1:0]    irqOut
);
  clrStrobe_t strb;

  dma_irq_ctrl u_ctrl (
    .clrWrEn   (clrWrEn),
    .clrWrData (clrWrData),
    .strb      (strb)
  );

  dma_irq_flags u_flags (
    .clk       (clk),
    .rstN      (rstN),
    .evtDone   (evtDone),
    .evtHalf   (evtHalf),
    .evtErr    (evtErr),
    .enDone    (enDone),
    .enHalf    (enHalf),
    .enErr     (enErr),
    .strb      (strb),
    .statusOut (statusOut),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker
  import dma_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    evtDone,
  input logic [NCH-1:0]    evtHalf,
  input logic [NCH-1:0]    evtErr,
  input logic [NCH-1:0]    enDone,
  input logic [NCH-1:0]    enHalf,
  input logic [NCH-1:0]    enErr,
  input logic              clrWrEn,
  input logic [STAT_W-1:0] clrWrData,
  input logic [STAT_W-1:0] statusOut,
  input logic [NCH-1:0]    irqOut
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (statusOut == '0 && irqOut == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam int B = c * FLD_PER;

    a_r2_done_sets: assert property (@(posedge clk) disable iff (!rstN)
      evtDone[c] |=> statusOut[B + F_DONE]);
    a_r2_err_sets: assert property (@(posedge clk) disable iff (!rstN)
      evtErr[c] |=> statusOut[B + F_ERR]);
    a_r3_glb_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
      statusOut[B + F_GLB] |-> (statusOut[B + F_ERR : B + F_DONE] != 3'b000));
    a_r3_flag_gives_glb: assert property (@(posedge clk) disable iff (!rstN)
      (statusOut[B + F_ERR : B + F_DONE] != 3'b000) |-> statusOut[B + F_GLB]);
    a_r5_glb_wipe: assert property (@(posedge clk) disable iff (!rstN)
      (clrWrEn && clrWrData[B + F_GLB] && !evtDone[c] && !evtHalf[c] && !evtErr[c])
      |=> (statusOut[B + F_ERR : B + F_GLB] == 4'b0000));
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (evtHalf[c] && clrWrEn && clrWrData[B + F_HALF]) |=> statusOut[B + F_HALF]);
    a_r8_irq_on: assert property (@(posedge clk) disable iff (!rstN)
      ((statusOut[B + F_DONE] && enDone[c]) || (statusOut[B + F_HALF] && enHalf[c]) ||
       (statusOut[B + F_ERR] && enErr[c])) |=> irqOut[c]);
    a_r8_irq_off: assert property (@(posedge clk) disable iff (!rstN)
      (statusOut[B + F_ERR : B + F_DONE] == 3'b000) |=> !irqOut[c]);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!clrWrEn && statusOut[B + F_ERR]) |=> statusOut[B + F_ERR]);
  end
endmodule

bind dma_irq_status dma_irq_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtDone   (evtDone),
  .evtHalf   (evtHalf),
  .evtErr    (evtErr),
  .enDone    (enDone),
  .enHalf    (enHalf),
  .enErr     (enErr),
  .clrWrEn   (clrWrEn),
  .clrWrData (clrWrData),
  .statusOut (statusOut),
  .irqOut    (irqOut)
);

// File: tb/sim_dma_irq_status.sv
`timescale 1ns/1ps
module sim_dma_irq_status;
  import dma_irq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] evtDone = '0, evtHalf = '0, evtErr = '0;
  logic [NCH-1:0] enDone = '0, enHalf = '0, enErr = '0;
  logic clrWrEn = 1'b0;
  logic [STAT_W-1:0] clrWrData = '0;
  logic [STAT_W-1:0] statusOut;
  logic [NCH-1:0] irqOut;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R2";

  // reference state: per channel [0]=end, [1]=midpoint, [2]=fault
  bit mFlag [NCH][3];
  bit mIrq [NCH];

  always #2 clk = ~clk;

  dma_irq_status u0 (
    .clk(clk), .rstN(rstN),
    .evtDone(evtDone), .evtHalf(evtHalf), .evtErr(evtErr),
    .enDone(enDone), .enHalf(enHalf), .enErr(enErr),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    bit ev, en, clr;
    bit nxtIrq;
    cycles++;
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) begin
        for (int k = 0; k < 3; k++) mFlag[c][k] = 0;
        mIrq[c] = 0;
      end else begin
        nxtIrq = 0;
        for (int k = 0; k < 3; k++) begin
          en = (k == 0) ? enDone[c] : (k == 1) ? enHalf[c] : enErr[c];
          if (mFlag[c][k] && en) nxtIrq = 1;
        end
        mIrq[c] = nxtIrq;
        for (int k = 0; k < 3; k++) begin
          ev  = (k == 0) ? evtDone[c] : (k == 1) ? evtHalf[c] : evtErr[c];
          clr = clrWrEn && (clrWrData[c*4 + k + 1] || clrWrData[c*4]);
          if (ev) mFlag[c][k] = 1;
          else if (clr) mFlag[c][k] = 0;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int c = 0; c < NCH; c++) begin
      check("R3", $sformatf("summary ch%0d (%s)", c, phase), statusOut[c*4],
            mFlag[c][0] | mFlag[c][1] | mFlag[c][2]);
      for (int k = 0; k < 3; k++)
        check("R2", $sformatf("flag ch%0d f%0d (%s)", c, k, phase), statusOut[c*4 + k + 1], mFlag[c][k]);
      check("R8", $sformatf("irq ch%0d (%s)", c, phase), irqOut[c], mIrq[c]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    evtDone = '0; evtHalf = '0; evtErr = '0;
    clrWrEn = 1'b0; clrWrData = '0;
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: state right after reset
    check("R1", "status after reset", statusOut == '0, 1'b1);
    check("R1", "irq after reset", irqOut == '0, 1'b1);

    // R2 / R7: events with all enables off
    phase = "R7";
    evtDone[0] = 1; evtHalf[2] = 1; evtErr[4] = 1;
    tick();
    check("R2", "ch0 end bit1", statusOut[1], 1'b1);
    check("R3", "ch0 summary bit0", statusOut[0], 1'b1);
    check("R2", "ch2 mid bit10", statusOut[10], 1'b1);
    check("R2", "ch4 fault bit19", statusOut[19], 1'b1);
    tick();
    check("R7", "no irq with enables off", irqOut == '0, 1'b1);
    check("R7", "flags kept with enables off", statusOut[19], 1'b1);

    // R8: enables on
    phase = "R8";
    enDone = '1; enHalf = '1; enErr = '1;
    tick();
    check("R8", "irq ch0", irqOut[0], 1'b1);
    check("R8", "irq ch2", irqOut[2], 1'b1);
    check("R8", "irq ch1 idle", irqOut[1], 1'b0);

    // R4: clear only ch0 end flag
    phase = "R4";
    clrWrEn = 1; clrWrData = 20'h00002;
    tick();
    check("R4", "ch0 end cleared", statusOut[1], 1'b0);
    check("R4", "ch0 summary drops", statusOut[0], 1'b0);
    check("R4", "ch2 mid untouched", statusOut[10], 1'b1);
    check("R4", "ch4 fault untouched", statusOut[19], 1'b1);
    tick();
    check("R8", "irq ch0 drops after clear", irqOut[0], 1'b0);

    // R9: clear word without strobe
    phase = "R9";
    clrWrData = '1;
    tick();
    check("R9", "ch2 mid kept", statusOut[10], 1'b1);
    check("R9", "ch4 fault kept", statusOut[19], 1'b1);

    // R5: summary clear of ch4
    phase = "R5";
    evtDone[4] = 1; evtHalf[4] = 1;
    tick();
    check("R2", "ch4 all three set", statusOut[19:17] == 3'b111, 1'b1);
    clrWrEn = 1; clrWrData = 20'h10000;
    tick();
    check("R5", "ch4 nibble wiped", statusOut[19:16] == 4'h0, 1'b1);
    check("R5", "ch2 unaffected", statusOut[10], 1'b1);

    // R6: set beats clear
    phase = "R6";
    evtHalf[1] = 1; clrWrEn = 1; clrWrData = 20'h00040;
    tick();
    check("R6", "ch1 mid set wins over own clear", statusOut[6], 1'b1);
    evtDone[3] = 1;
    tick();
    evtErr[3] = 1; clrWrEn = 1; clrWrData = 20'h01000;
    tick();
    check("R6", "ch3 fault set wins over summary clear", statusOut[15], 1'b1);
    check("R5", "ch3 end wiped by summary clear", statusOut[13], 1'b0);

    // random traffic with frequent collisions
    phase = "R4 random";
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        enDone = NCH'($urandom); enHalf = NCH'($urandom); enErr = NCH'($urandom);
      end
      for (int c = 0; c < NCH; c++) begin
        evtDone[c] = ($urandom % 8) == 0;
        evtHalf[c] = ($urandom % 8) == 0;
        evtErr[c]  = ($urandom % 8) == 0;
      end
      clrWrEn = ($urandom % 3) == 0;
      clrWrData = STAT_W'($urandom);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule